// File: doc/BRIEF.md
# GPIO Interrupt Trigger Controller

A 32-pin general-purpose I/O block with a small memory-mapped register window. Every per-pin attribute (output level, trigger type, trigger polarity, debounce, interrupt enable and dual-edge detection) is held in one state word. Software changes that word only through a set address and a clear address. A write changes only the bits that are 1 in the written mask, so two agents can update different pins without a read-modify-write race.

Each pin input passes through a two-flop synchronizer and, when debounce is on, a stability filter. The filtered level is then checked against the pin's trigger setting. The setting is rising edge, falling edge, high level or low level, chosen by a type bit and a polarity bit. A separate dual-edge enable, when set, overrides both bits and catches either edge. Edge hits latch into a status word until software writes 1 to clear them. Level conditions show in the status word for as long as they hold. One interrupt line is the OR of all status bits that are enabled.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: A write to a set address (output 0x000, type 0x010, polarity 0x020, debounce 0x030, interrupt enable 0x040, dual-edge 0x0B0) sets exactly the 1 bits of the data. A write to the set address + 4 clears exactly those bits. All other bits keep their value. The state word reads back at set address + 8.
- R2: `pin_out` always equals the output state word.
- R3: With type=1 and polarity=1, a rising edge of the filtered pin level sets that pin's status bit (read at 0x060). A falling edge does not.
- R4: With type=1 and polarity=0, a falling edge sets the status bit. A rising edge does not.
- R5: With type=0 and polarity=1, the status bit is 1 exactly while the filtered level is high.
- R6: With type=0 and polarity=0, the status bit is 1 exactly while the filtered level is low.
- R7: While dual-edge is set for a pin, both edges set its status bit whatever its type and polarity bits hold.
- R8: A latched edge status bit stays 1 until a write to 0x064 has a 1 in that bit. Writes with 0 in that bit leave it set.
- R9: `irq_o` is 1 exactly when some status bit and the same interrupt-enable bit are both 1.
- R10: Without debounce, a pin change appears at 0x068 (filtered level) three clocks after it reaches `pin_in`. With debounce, it appears only after the level has stayed stable for DB_TICKS further clocks (six clocks in all for DB_TICKS=4). A shorter pulse is dropped.
- R11: Reads of any offset not listed in R1, R3 or R10 return zero.
- R12: After reset every state word and every latched status bit is 0, `pin_out` is 0 and `irq_o` is 0. Low pins therefore show level-low status (all ones at 0x060).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data levels |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checks assume each write lasts exactly one cycle, with address and data stable while `bus_wr` is high. They also assume that a write to a clear address is never taken as a set. The bench drives every bus and pin input at the falling edge and holds each write for a single clock. The latched-status property excludes pins whose mode changes in that cycle, because the stimulus reconfigures pins only while their edge status is already cleared.

// File: rtl/gpio_trig_pkg.sv
`timescale 1ns/1ps
package gpio_trig_pkg;
  localparam int ADDR_W = 8;

  typedef enum int {
    AT_OUT   = 0,
    AT_ETYPE = 1,
    AT_POL   = 2,
    AT_DBNC  = 3,
    AT_IEN   = 4,
    AT_DEDGE = 5
  } attr_e;

  localparam int N_ATTR = 6;

  localparam logic [ADDR_W-1:0] OFF_STAT     = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_STAT_CLR = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_PIN      = 8'h68;

  // set address of an attribute; clear = +4, state = +8
  function automatic logic [ADDR_W-1:0] set_off(input int a);
    if (a == int'(AT_DEDGE)) return 8'hB0;
    return ADDR_W'(a * 16);
  endfunction
endpackage

// File: rtl/gpio_attr_reg.sv
`timescale 1ns/1ps
module gpio_attr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = |(set_m | clr_m);
    q_d  = (q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/gpio_in_filter.sv
`timescale 1ns/1ps
module gpio_in_filter #(
  parameter int W        = 32,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] db_en,
  output logic [W-1:0] level_o
);
  localparam int CW = $clog2(DB_TICKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DB_TICKS - 1);

  logic [W-1:0] sync1, sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q, cnt_d;
    logic          filt_q, filt_d;

    always_comb begin
      cnt_d  = '0;
      filt_d = filt_q;
      if (sync2[i] != filt_q) begin
        if (!db_en[i] || cnt_q == CNT_LAST) filt_d = sync2[i];
        else                                cnt_d  = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_d;
        filt_q <= filt_d;
      end
    end

    assign level_o[i] = filt_q;
  end
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] etype,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] dedge,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] stat,
  output logic [W-1:0] edge_q,
  output logic [W-1:0] emode
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, hit, lvl, edge_d;

  always_comb begin
    rise   = level & ~prev_q;
    fall   = ~level & prev_q;
    emode  = dedge | etype;
    // dual-edge wins over type and polarity
    hit    = (dedge & (rise | fall))
           | (~dedge & etype & ((pol & rise) | (~pol & fall)));
    lvl    = ~emode & ~(level ^ pol);
    edge_d = (edge_q & ~clr_m & emode) | hit;
    stat   = (emode & edge_q) | lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= level;
      edge_q <= edge_d;
    end
  end
endmodule

// File: rtl/gpio_trig_ctrl.sv
`timescale 1ns/1ps
module gpio_trig_ctrl
  import gpio_trig_pkg::*;
#(
  parameter int NPIN     = 32,
  parameter int DB_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic              irq_o
);
  logic [1:0]      rsync;
  logic            rst_int_n;
  logic [NPIN-1:0] attr_q [N_ATTR];
  logic [NPIN-1:0] set_m  [N_ATTR];
  logic [NPIN-1:0] clr_m  [N_ATTR];
  logic [NPIN-1:0] stat_clr, level, int_stat, edge_stat, edge_mode, ien_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
    localparam logic [ADDR_W-1:0] A_SET = set_off(a);
    localparam logic [ADDR_W-1:0] A_CLR = A_SET + 8'd4;
    assign set_m[a] = (bus_wr && bus_addr == A_SET) ? bus_wdata : '0;
    assign clr_m[a] = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;
    gpio_attr_reg #(.W(NPIN)) u_reg (
      .clk(clk), .rst_n(rst_int_n),
      .set_m(set_m[a]), .clr_m(clr_m[a]), .q(attr_q[a])
    );
  end

  assign stat_clr = (bus_wr && bus_addr == OFF_STAT_CLR) ? bus_wdata : '0;

  gpio_in_filter #(.W(NPIN), .DB_TICKS(DB_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in),
    .db_en(attr_q[AT_DBNC]), .level_o(level)
  );

  gpio_trig_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst_n(rst_int_n), .level(level),
    .etype(attr_q[AT_ETYPE]), .pol(attr_q[AT_POL]), .dedge(attr_q[AT_DEDGE]),
    .clr_m(stat_clr), .stat(int_stat), .edge_q(edge_stat), .emode(edge_mode)
  );

  always_comb begin
    bus_rdata = '0;
    for (int a = 0; a < N_ATTR; a++)
      if (bus_addr == set_off(a) + 8'd8) bus_rdata = attr_q[a];
    if (bus_addr == OFF_STAT) bus_rdata = int_stat;
    if (bus_addr == OFF_PIN)  bus_rdata = level;
  end

  assign ien_q   = attr_q[AT_IEN];
  assign pin_out = attr_q[AT_OUT];
  assign irq_o   = |(int_stat & ien_q);
endmodule

// File: rtl/gpio_trig_chk.sv
`timescale 1ns/1ps
module gpio_trig_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic            irq_o,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] edge_q,
  input logic [NPIN-1:0] emode,
  input logic [NPIN-1:0] ien
);
  logic [NPIN-1:0] clr_w;
  assign clr_w = (bus_wr && bus_addr == 8'h64) ? bus_wdata : '0;

  // R1
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R1
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || !bus_wr) |=>
      (($past(edge_q & ~clr_w & emode) & emode & ~edge_q) == '0));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(stat & ien)));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 8'hC0) |-> (bus_rdata == '0));
endmodule

bind gpio_trig_ctrl gpio_trig_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .irq_o(irq_o), .stat(int_stat), .edge_q(edge_stat), .emode(edge_mode),
  .ien(ien_q)
);

// File: tb/tb_gpio_trig_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_trig_ctrl;
  logic        clk, rst_n, bus_wr, irq_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out;
  int          checks, fails;

  gpio_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
  endtask

  task automatic settle;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h08, d); check("R12 out state", d, 32'h0);
    rd(8'h18, d); check("R12 type state", d, 32'h0);
    rd(8'hB8, d); check("R12 dual state", d, 32'h0);
    rd(8'h60, d); check("R12 status all level-low", d, 32'hFFFF_FFFF);
    check("R12 pin_out", pin_out, 32'h0);
    check("R12 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(8'h00, 32'h0000_00F0);
    wr(8'h00, 32'h0F00_0000);
    rd(8'h08, d); check("R1 set keeps others", d, 32'h0F00_00F0);
    check("R2 pin_out", pin_out, 32'h0F00_00F0);
    wr(8'h04, 32'h0000_0030);
    rd(8'h08, d); check("R1 clear mask", d, 32'h0F00_00C0);
    wr(8'h04, 32'h0);
    rd(8'h08, d); check("R1 zero mask", d, 32'h0F00_00C0);
    check("R2 pin_out after clear", pin_out, 32'h0F00_00C0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(8'h10, 32'h1); wr(8'h20, 32'h1);
    rd(8'h60, d); check("R3 idle", d & 32'h1, 32'h0);
    pin(0, 1'b1); settle;
    rd(8'h60, d); check("R3 rising latched", d & 32'h1, 32'h1);
    pin(0, 1'b0); settle;
    rd(8'h60, d); check("R8 held after fall", d & 32'h1, 32'h1);
    wr(8'h64, 32'hFFFF_FFFE);
    rd(8'h60, d); check("R8 zero bit no clear", d & 32'h1, 32'h1);
    wr(8'h64, 32'h1);
    rd(8'h60, d); check("R8 w1c", d & 32'h1, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(8'h10, 32'h2);
    pin(1, 1'b1); settle;
    rd(8'h60, d); check("R4 rise ignored", d & 32'h2, 32'h0);
    pin(1, 1'b0); settle;
    rd(8'h60, d); check("R4 falling latched", d & 32'h2, 32'h2);
    wr(8'h64, 32'h2);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h20, 32'h4);
    rd(8'h60, d); check("R5 low input", d & 32'h4, 32'h0);
    pin(2, 1'b1); settle;
    rd(8'h60, d); check("R5 high input", d & 32'h4, 32'h4);
    pin(2, 1'b0); settle;
    rd(8'h60, d); check("R5 follows drop", d & 32'h4, 32'h0);
    pin(3, 1'b1); settle;
    rd(8'h60, d); check("R6 high input", d & 32'h8, 32'h0);
    pin(3, 1'b0); settle;
    rd(8'h60, d); check("R6 low input", d & 32'h8, 32'h8);
  endtask

  task automatic t_dedge;
    logic [31:0] d;
    wr(8'h10, 32'h10); wr(8'h20, 32'h10); wr(8'hB0, 32'h10);
    rd(8'hB8, d); check("R7 dual state", d, 32'h10);
    pin(4, 1'b1); settle;
    rd(8'h60, d); check("R7 rising", d & 32'h10, 32'h10);
    wr(8'h64, 32'h10);
    pin(4, 1'b0); settle;
    rd(8'h60, d); check("R7 falling overrides polarity", d & 32'h10, 32'h10);
    wr(8'h64, 32'h10);
    wr(8'hB4, 32'h10);
    rd(8'hB8, d); check("R7 dual cleared", d, 32'h0);
    pin(4, 1'b1); settle; wr(8'h64, 32'h10);
    pin(4, 1'b0); settle;
    rd(8'h60, d); check("R7 rising-only again", d & 32'h10, 32'h0);
  endtask

  task automatic t_irq;
    wr(8'h10, 32'h20); wr(8'h20, 32'h20);
    pin(5, 1'b1); settle;
    check("R9 masked", {31'b0, irq_o}, 32'h0);
    wr(8'h40, 32'h20);
    #1 check("R9 enabled", {31'b0, irq_o}, 32'h1);
    wr(8'h64, 32'h20);
    #1 check("R9 cleared", {31'b0, irq_o}, 32'h0);
    wr(8'h40, 32'h8);
    #1 check("R9 level pin", {31'b0, irq_o}, 32'h1);
    wr(8'h44, 32'h28);
    #1 check("R9 disabled", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_debounce;
    logic [31:0] d;
    wr(8'h20, 32'h40); wr(8'h30, 32'h40);
    pin(6, 1'b1); pin(6, 1'b0); settle;
    rd(8'h68, d); check("R10 glitch level", d & 32'h40, 32'h0);
    rd(8'h60, d); check("R10 glitch status", d & 32'h40, 32'h0);
    bus_addr = 8'h68;
    pin(6, 1'b1);
    repeat (4) @(negedge clk);
    #1 check("R10 not yet", bus_rdata & 32'h40, 32'h0);
    repeat (3) @(negedge clk);
    #1 check("R10 accepted", bus_rdata & 32'h40, 32'h40);
    pin(7, 1'b1);
    repeat (2) @(negedge clk);
    #1 check("R10 raw before", bus_rdata & 32'h80, 32'h0);
    @(negedge clk);
    #1 check("R10 raw three clocks", bus_rdata & 32'h80, 32'h80);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h0C, d); check("R11 0x0C", d, 32'h0);
    rd(8'hC0, d); check("R11 0xC0", d, 32'h0);
    rd(8'hFC, d); check("R11 0xFC", d, 32'h0);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_setclr;
    t_rise;
    t_fall;
    t_level;
    t_dedge;
    t_irq;
    t_debounce;
    t_unmapped;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule